// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access may proceed once a translation table walk has returned its descriptors. It takes the first-level descriptor, the second-level descriptor (which only matters when the first level points to a page table), the virtual address, a 32-bit domain control word holding a 2-bit mode for each of sixteen domains, and the access type (user or privileged, read or write).

The domain named by the first-level descriptor is checked first. A domain in no-access or reserved mode rejects the access with a domain fault. A manager domain accepts it without reading any permission bits. A client domain goes on to a permission check. That check reads the 2-bit permission field of a section directly. For a large or small page, it picks one of four per-quarter fields using two bits of the virtual address. The verdict is registered and appears one cycle after the request strobe.

Top module: `access_check`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `rsp_valid`, `allow` and `fault` are all 0.
- R2: A request taken on a rising edge with `req_valid` high produces `rsp_valid` = 1 together with its verdict after that edge. With `req_valid` low, `rsp_valid` returns to 0 and `allow` and `fault` keep their last values.
- R3: The domain number is `l1_desc[8:5]`. Its mode is `dom_ctrl[2d+1:2d]`: 00 no access, 01 client, 10 reserved, 11 manager. All sixteen domains are usable, up to domain 15 at bits [31:30].
- R4: A no-access domain (00) gives `allow` = 0 and `fault` = 01 for every descriptor and access type. This includes an invalid descriptor type, because the domain check has priority.
- R5: A reserved domain (10) is handled like a no-access domain: `fault` = 01.
- R6: A manager domain (11) allows any access to a valid translation, whatever its permission bits are.
- R7: The first-level type is `l1_desc[1:0]`: 00 invalid, 01 coarse table, 10 section, 11 fine table. A section takes its permission field from `l1_desc[11:10]` and ignores `l2_desc`. Coarse and fine tables take their permission field from `l2_desc`.
- R8: The second-level type is `l2_desc[1:0]`: 00 invalid, 01 large page, 10 small page, 11 tiny page. A large page selects its subpage with `va[15:14]`. Subpage k uses field `l2_desc[2k+5:2k+4]`, and `va[11:10]` has no effect.
- R9: A small page selects its subpage with `va[11:10]`, using the same field layout as a large page. `va[15:14]` has no effect.
- R10: A tiny page always uses `l2_desc[5:4]`.
- R11: In a client domain, permission field 00 allows only privileged reads. Field 01 allows privileged reads and writes and no user access. Field 10 adds user reads. Field 11 allows everything.
- R12: `fault` is 00 when the access is allowed, 01 for a domain fault and 10 for a permission fault. It is never 11, and `allow` is high exactly when `fault` is 00.
- R13: In a client or manager domain, an invalid first-level type, or an invalid second-level type under a coarse or fine table, gives `fault` = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; the inputs below are taken when it is high |
| l1_desc | input | 32 | First-level descriptor |
| l2_desc | input | 32 | Second-level descriptor (used for table types only) |
| va | input | 32 | Virtual address of the access |
| dom_ctrl | input | 32 | Domain mode word, 2 bits per domain |
| is_user | input | 1 | 1 for a user access, 0 for a privileged access |
| is_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Verdict is valid this cycle |
| allow | output | 1 | Access permitted |
| fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |

## Verification
The bench builds the block with its default parameters: sixteen domains and 32-bit descriptor and address words. With these values the highest domain slot of the control word can be reached, as can every one of the four subpage fields of a page descriptor. The bench also covers both subpage selector positions, including one address in which only the selector that does not apply is set. It sweeps all permission encodings against all four access kinds. It also checks that a domain fault outranks an invalid descriptor, and that an idle cycle holds the last verdict.

// File: rtl/access_check_pkg.sv
package access_check_pkg;

    localparam int AP_W             = 2;
    localparam int SUBPAGES         = 4;
    localparam int SUBPAGE_BASE_LSB = 4;
    localparam int SECTION_AP_LSB   = 10;
    localparam int DOMAIN_LSB       = 5;
    localparam int LARGE_SEL_LSB    = 14;
    localparam int SMALL_SEL_LSB    = 10;

    typedef enum logic [1:0] {
        L1_INVALID = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_INVALID = 2'b00,
        L2_LARGE   = 2'b01,
        L2_SMALL   = 2'b10,
        L2_TINY    = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        DOM_BLOCKED = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10
    } fault_e;

    typedef struct packed {
        logic user;
        logic write;
    } acc_kind_t;

    typedef struct packed {
        logic   allow;
        fault_e code;
    } verdict_t;

    // Permission field meaning for a client domain.
    function automatic logic ap_permits(logic [AP_W-1:0] ap, acc_kind_t acc);
        logic ok;
        case (ap)
            2'b00:   ok = !acc.user && !acc.write;
            2'b01:   ok = !acc.user;
            2'b10:   ok = !acc.user || !acc.write;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/domain_lookup.sv
module domain_lookup
    import access_check_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    localparam int IDX_W      = $clog2(NUM_DOMAINS),
    localparam int DCR_W      = 2 * NUM_DOMAINS
) (
    input  logic [DCR_W-1:0] dom_ctrl,
    input  logic [IDX_W-1:0] dom_idx,
    output dom_mode_e        mode
);

    logic [1:0] slot [NUM_DOMAINS];

    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_slot
        assign slot[d] = dom_ctrl[2*d +: 2];
    end

    assign mode = dom_mode_e'(slot[dom_idx]);

endmodule

// File: rtl/ap_select.sv
module ap_select
    import access_check_pkg::*;
#(
    parameter int DESC_W = 32,
    parameter int VA_W   = 32,
    localparam int SEL_W = $clog2(SUBPAGES)
) (
    input  logic [DESC_W-1:0] l1_desc,
    input  logic [DESC_W-1:0] l2_desc,
    input  logic [VA_W-1:0]   va,
    output logic [AP_W-1:0]   ap,
    output logic              desc_ok
);

    logic [AP_W-1:0] sub_ap [SUBPAGES];
    l1_kind_e        k1;
    l2_kind_e        k2;

    for (genvar k = 0; k < SUBPAGES; k++) begin : g_sub
        assign sub_ap[k] = l2_desc[SUBPAGE_BASE_LSB + AP_W*k +: AP_W];
    end

    assign k1 = l1_kind_e'(l1_desc[1:0]);
    assign k2 = l2_kind_e'(l2_desc[1:0]);

    always_comb begin
        ap      = '0;
        desc_ok = 1'b1;
        case (k1)
            L1_INVALID: desc_ok = 1'b0;
            L1_SECTION: ap = l1_desc[SECTION_AP_LSB +: AP_W];
            default: begin
                case (k2)
                    L2_INVALID: desc_ok = 1'b0;
                    L2_LARGE:   ap = sub_ap[va[LARGE_SEL_LSB +: SEL_W]];
                    L2_SMALL:   ap = sub_ap[va[SMALL_SEL_LSB +: SEL_W]];
                    default:    ap = sub_ap[0];
                endcase
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{l1_desc[DESC_W-1:12], l1_desc[9:2],
                           l2_desc[DESC_W-1:12], l2_desc[3:2],
                           va[VA_W-1:16], va[13:12], va[9:0]};

endmodule

// File: rtl/access_check.sv
module access_check
    import access_check_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    parameter int DESC_W      = 32,
    parameter int VA_W        = 32,
    localparam int IDX_W      = $clog2(NUM_DOMAINS),
    localparam int DCR_W      = 2 * NUM_DOMAINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DESC_W-1:0] l1_desc,
    input  logic [DESC_W-1:0] l2_desc,
    input  logic [VA_W-1:0]   va,
    input  logic [DCR_W-1:0]  dom_ctrl,
    input  logic              is_user,
    input  logic              is_write,
    output logic              rsp_valid,
    output logic              allow,
    output logic [1:0]        fault
);

    dom_mode_e       mode;
    logic [AP_W-1:0] ap;
    logic            desc_ok;
    acc_kind_t       acc;
    verdict_t        verdict;

    domain_lookup #(.NUM_DOMAINS(NUM_DOMAINS)) i_dom (
        .dom_ctrl (dom_ctrl),
        .dom_idx  (l1_desc[DOMAIN_LSB +: IDX_W]),
        .mode     (mode)
    );

    ap_select #(.DESC_W(DESC_W), .VA_W(VA_W)) i_ap (
        .l1_desc (l1_desc),
        .l2_desc (l2_desc),
        .va      (va),
        .ap      (ap),
        .desc_ok (desc_ok)
    );

    assign acc = '{user: is_user, write: is_write};

    always_comb begin
        case (mode)
            DOM_BLOCKED, DOM_RSVD: verdict = '{allow: 1'b0, code: FLT_DOMAIN};
            default: begin
                if (!desc_ok)
                    verdict = '{allow: 1'b0, code: FLT_PERM};
                else if (mode == DOM_MANAGER || ap_permits(ap, acc))
                    verdict = '{allow: 1'b1, code: FLT_NONE};
                else
                    verdict = '{allow: 1'b0, code: FLT_PERM};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            allow     <= 1'b0;
            fault     <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                allow <= verdict.allow;
                fault <= verdict.code;
            end
        end
    end

endmodule

// File: rtl/access_check_props.sv
module access_check_props #(
    parameter int NUM_DOMAINS = 16,
    parameter int DESC_W      = 32,
    parameter int VA_W        = 32,
    localparam int IDX_W      = $clog2(NUM_DOMAINS),
    localparam int DCR_W      = 2 * NUM_DOMAINS
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DESC_W-1:0] l1_desc,
    input logic [DESC_W-1:0] l2_desc,
    input logic [VA_W-1:0]   va,
    input logic [DCR_W-1:0]  dom_ctrl,
    input logic              is_user,
    input logic              is_write,
    input logic              rsp_valid,
    input logic              allow,
    input logic [1:0]        fault
);

    logic [IDX_W-1:0] d_idx;
    logic [1:0]       d_mode;
    logic             is_section;

    assign d_idx      = l1_desc[5 +: IDX_W];
    assign d_mode     = dom_ctrl[{d_idx, 1'b0} +: 2];
    assign is_section = (l1_desc[1:0] == 2'b10);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !allow && fault == 2'b00));

    p_resp_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(allow) && $stable(fault)));

    // Covers R4 and R5: blocked or reserved domain always faults on domain
    p_domain_deny_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !d_mode[0]) |=> (!allow && fault == 2'b01));

    p_manager_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && d_mode == 2'b11 && is_section) |=> allow);

    p_priv_read_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && d_mode == 2'b01 && is_section && !is_user && !is_write) |=> allow);

    p_code_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (fault != 2'b11 && allow == (fault == 2'b00)));

    logic unused_props;
    assign unused_props = ^{l2_desc, va, l1_desc[DESC_W-1:0]};

endmodule

bind access_check access_check_props #(
    .NUM_DOMAINS(NUM_DOMAINS), .DESC_W(DESC_W), .VA_W(VA_W)
) i_props (.*);

// File: tb/test_access_check.sv
module test_access_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] l1_desc, l2_desc, va, dom_ctrl;
    logic        is_user, is_write;
    logic        rsp_valid, allow;
    logic [1:0]  fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    access_check i_access_check (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .l1_desc(l1_desc), .l2_desc(l2_desc), .va(va), .dom_ctrl(dom_ctrl),
        .is_user(is_user), .is_write(is_write),
        .rsp_valid(rsp_valid), .allow(allow), .fault(fault)
    );

    // d0 client, d1 manager, d2 no access, d3 reserved, d4..d15 client
    localparam logic [31:0] DCR = 32'h5555_558D;

    typedef struct packed {
        logic [31:0] l1;
        logic [31:0] l2;
        logic [31:0] va;
        logic        user;
        logic        wr;
        logic        ok;
        logic [1:0]  code;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{32'hC42, 32'h0,   32'h0,    1'b0, 1'b0, 1'b0, 2'b01, 4'd4},  // R4 no access
        '{32'h040, 32'h0,   32'h0,    1'b0, 1'b0, 1'b0, 2'b01, 4'd4},  // R4 beats invalid type
        '{32'hC62, 32'h0,   32'h0,    1'b0, 1'b0, 1'b0, 2'b01, 4'd5},  // R5 reserved
        '{32'h022, 32'h0,   32'h0,    1'b1, 1'b1, 1'b1, 2'b00, 4'd6},  // R6 manager, AP 00
        '{32'h020, 32'h0,   32'h0,    1'b0, 1'b0, 1'b0, 2'b10, 4'd13}, // R13 manager, invalid L1
        '{32'h001, 32'h931, 32'h0000, 1'b1, 1'b1, 1'b1, 2'b00, 4'd8},  // R8 sp0=11
        '{32'h001, 32'h931, 32'h4000, 1'b1, 1'b0, 1'b0, 2'b10, 4'd8},  // R8 sp1=00
        '{32'h001, 32'h931, 32'h8000, 1'b1, 1'b0, 1'b0, 2'b10, 4'd8},  // R8 sp2=01 user
        '{32'h001, 32'h931, 32'h8000, 1'b0, 1'b1, 1'b1, 2'b00, 4'd8},  // R8 sp2=01 priv write
        '{32'h001, 32'h931, 32'hC000, 1'b1, 1'b0, 1'b1, 2'b00, 4'd8},  // R8 sp3=10 user read
        '{32'h001, 32'h931, 32'hC000, 1'b1, 1'b1, 1'b0, 2'b10, 4'd8},  // R8 sp3=10 user write
        '{32'h001, 32'h931, 32'h0C00, 1'b1, 1'b1, 1'b1, 2'b00, 4'd8},  // R8 va[11:10] ignored
        '{32'h001, 32'h932, 32'h0400, 1'b1, 1'b0, 1'b0, 2'b10, 4'd9},  // R9 sp1=00
        '{32'h001, 32'h932, 32'h0C00, 1'b1, 1'b0, 1'b1, 2'b00, 4'd9},  // R9 sp3=10
        '{32'h001, 32'h932, 32'hC000, 1'b1, 1'b1, 1'b1, 2'b00, 4'd9},  // R9 va[15:14] ignored
        '{32'h001, 32'h933, 32'hFC00, 1'b1, 1'b1, 1'b1, 2'b00, 4'd10}, // R10 tiny [5:4]=11
        '{32'h001, 32'hFC3, 32'hC000, 1'b1, 1'b0, 1'b0, 2'b10, 4'd10}, // R10 tiny [5:4]=00
        '{32'h001, 32'h930, 32'h0,    1'b0, 1'b0, 1'b0, 2'b10, 4'd13}, // R13 invalid L2
        '{32'h003, 32'h932, 32'h0,    1'b1, 1'b1, 1'b1, 2'b00, 4'd7},  // R7 fine table uses L2
        '{32'h5E2, 32'h0,   32'h0,    1'b0, 1'b1, 1'b1, 2'b00, 4'd3},  // R3 domain 15 client
        '{32'h5E2, 32'h0,   32'h0,    1'b1, 1'b0, 1'b0, 2'b10, 4'd3},  // R3 domain 15 AP 01
        '{32'hC02, 32'h0,   32'h0,    1'b1, 1'b1, 1'b1, 2'b00, 4'd7}   // R7 section ignores L2
    };

    function automatic logic ref_ok(logic [1:0] ap, logic user, logic wr);
        if (user) return (ap == 2'b11) || (ap == 2'b10 && !wr);
        return (ap != 2'b00) || !wr;
    endfunction

    task automatic check_out(input logic ev, input logic eok, input logic [1:0] ecode,
                             input string tag);
        checks++;
        if (rsp_valid !== ev || allow !== eok || fault !== ecode) begin
            errors++;
            $display("FAIL %s: got valid=%0b allow=%0b fault=%02b, expected valid=%0b allow=%0b fault=%02b",
                     tag, rsp_valid, allow, fault, ev, eok, ecode);
        end
    endtask

    task automatic issue(input logic [31:0] l1, input logic [31:0] l2, input logic [31:0] a,
                         input logic u, input logic w);
        l1_desc = l1; l2_desc = l2; va = a; is_user = u; is_write = w;
        req_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0;
        l1_desc = '0; l2_desc = '0; va = '0; dom_ctrl = DCR;
        is_user = 1'b0; is_write = 1'b0;
        repeat (3) @(negedge clk);
        check_out(1'b0, 1'b0, 2'b00, "R1 reset state");
        rst = 1'b0;

        foreach (VECS[i]) begin
            issue(VECS[i].l1, VECS[i].l2, VECS[i].va, VECS[i].user, VECS[i].wr);
            check_out(1'b1, VECS[i].ok, VECS[i].code, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R11 sweep: section in client domain 0, every AP and access kind
        for (int ap = 0; ap < 4; ap++) begin
            for (int k = 0; k < 4; k++) begin
                logic e;
                e = ref_ok(ap[1:0], k[1], k[0]);
                issue({20'h0, ap[1:0], 10'h002}, 32'h0, 32'h0, k[1], k[0]);
                check_out(1'b1, e, e ? 2'b00 : 2'b10, $sformatf("R11 ap=%0d user=%0d wr=%0d", ap, k[1], k[0]));
            end
        end

        // R2 one-cycle latency and hold while idle
        issue(32'hC42, 32'h0, 32'h0, 1'b0, 1'b0);
        check_out(1'b1, 1'b0, 2'b01, "R2 response after strobe");
        req_valid = 1'b0;
        l1_desc = 32'hC02; is_user = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, 2'b01, "R2 idle holds verdict");
        @(negedge clk);
        check_out(1'b0, 1'b0, 2'b01, "R2 second idle cycle");

        // R6 manager domain with changed control word: domain 0 as manager
        dom_ctrl = DCR | 32'h3;
        issue(32'h002, 32'h0, 32'h0, 1'b1, 1'b1);
        check_out(1'b1, 1'b1, 2'b00, "R6 manager ignores AP 00");
        dom_ctrl = DCR;

        // R1 reset while a request is pending
        issue(32'hC02, 32'h0, 32'h0, 1'b1, 1'b1);
        check_out(1'b1, 1'b1, 2'b00, "R12 allow before reset");
        rst = 1'b1;
        @(negedge clk);
        check_out(1'b0, 1'b0, 2'b00, "R1 reset clears outputs");
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule